// File: doc/BRIEF.md
# Striped Multi-Bank Data Scratchpad

This block is an on-chip data RAM shared by two CPU data ports that may both issue an access in the same cycle. Storage is split into several independent single-ported banks. Consecutive 32-bit words are laid out across the banks within one row, so a linear walk through memory visits every bank before it returns to the first one. Two accesses that land in different banks complete together. Two accesses that need the same bank are serialised: one is granted and the other is held off for that cycle.

Each port presents a request, a write flag, a word address, four byte enables and write data. The block answers in the same cycle with a grant. A port that is not granted keeps its request asserted and is served on a later cycle. Read data comes back on the cycle after the grant, together with a valid flag. A saturating counter records how many cycles included a stalled request, for profiling bank pressure.

Arbitration alternates fairly under contention. Port 0 wins a same-bank clash by default. A port that has just lost a clash wins the next one, so no port waits more than one cycle at a time. Two reads of the very same word do not clash: the bank performs one read and both ports receive the data.

Top module: `banked_scratchpad`

## Requirements
- R1: The bank of a word address is its bits [2:0] and the row within the bank is its bits [11:3]. Two requests clash only when their bits [2:0] are equal.
- R2: Two requests in the same cycle that target different banks are both granted in that cycle.
- R3: When both ports request the same bank and neither lost a clash in the previous cycle, port 0 is granted and port 1 is not.
- R4: A port that requested and was not granted, and that requests again in the next cycle, is granted in that next cycle.
- R5: Two reads of the same word address in one cycle are both granted, and both ports receive the same data.
- R6: A granted read raises that port's read-valid flag on the next cycle, with the stored word on its read data. At any other time the valid flag is low and the read data is zero.
- R7: On a granted write, byte lane i (bits 8i+7..8i) is updated only if byte enable bit i is 1. The other lanes keep their old value.
- R8: The 16-bit stall counter rises by one after each cycle in which a request went ungranted, holds otherwise, and stops at 65535.
- R9: After reset, both grants are low while nothing is requested, both valid flags are low and the stall counter reads zero.
- R10: A write that is not granted leaves memory unchanged.
- R11: A grant is never given to a port that is not requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| p0_req | input | 1 | Port 0 access request |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | 12 | Port 0 word address |
| p0_be | input | 4 | Port 0 byte enables |
| p0_wdata | input | 32 | Port 0 write data |
| p0_gnt | output | 1 | Port 0 access accepted this cycle |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_rdata | output | 32 | Port 0 read data |
| p1_req | input | 1 | Port 1 access request |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | 12 | Port 1 word address |
| p1_be | input | 4 | Port 1 byte enables |
| p1_wdata | input | 32 | Port 1 write data |
| p1_gnt | output | 1 | Port 1 access accepted this cycle |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | 32 | Port 1 read data |
| stall_count | output | 16 | Saturating count of cycles with a stalled request |

## Verification
The stall-counter and fairness properties assume that no port requests while the internal reset synchroniser is still holding the block in reset. They also assume that every request input is a known value on each clock edge. The stimulus drives all requests low from the start of reset until three cycles after release, and changes inputs only on falling edges. The alternation property assumes a port that lost a clash holds its request, so the stimulus re-presents every ungranted access unchanged on the next cycle.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // Which port wins the next same-bank clash.
  typedef enum logic {
    FAV_P0 = 1'b0,
    FAV_P1 = 1'b1
  } favour_e;
endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(DEPTH),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int b = 0; b < BE_W; b++) begin
        if (be[b]) store[row][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) rdata_q <= store[row];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/sp_arbiter.sv
module sp_arbiter #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req0,
  input  logic              we0,
  input  logic [ADDR_W-1:0] addr0,
  input  logic              req1,
  input  logic              we1,
  input  logic [ADDR_W-1:0] addr1,
  output logic              gnt0,
  output logic              gnt1,
  output logic [CNT_W-1:0]  stall_count
);
  import sp_pkg::*;

  favour_e          fav_q, fav_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             same_bank, shared_read, clash, cnt_en, fav_en;

  always_comb begin
    same_bank   = (addr0[BANK_W-1:0] == addr1[BANK_W-1:0]);
    shared_read = !we0 && !we1 && (addr0 == addr1);
    clash       = req0 && req1 && same_bank && !shared_read;
    gnt0        = req0 && !(clash && (fav_q == FAV_P1));
    gnt1        = req1 && !(clash && (fav_q == FAV_P0));
    // Loser of this clash wins the next one.
    fav_d       = (clash && (fav_q == FAV_P0)) ? FAV_P1 : FAV_P0;
    fav_en      = (fav_d != fav_q);
    cnt_en      = clash && (cnt_q != {CNT_W{1'b1}});
    cnt_d       = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fav_q <= FAV_P0;
      cnt_q <= '0;
    end else begin
      if (fav_en) fav_q <= fav_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign stall_count = cnt_q;
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_DEPTH = 512,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int ROW_W     = $clog2(BANK_DEPTH),
  localparam int ADDR_W    = BANK_W + ROW_W,
  localparam int BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_req,
  input  logic              p0_we,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [BE_W-1:0]   p0_be,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic              p0_gnt,
  output logic              p0_rvalid,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_req,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [BE_W-1:0]   p1_be,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic              p1_gnt,
  output logic              p1_rvalid,
  output logic [DATA_W-1:0] p1_rdata,
  output logic [CNT_W-1:0]  stall_count
);
  logic rst_n_int;
  logic req0_q, req1_q;
  logic gnt0, gnt1;

  sp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // No request is seen while the block is still in reset.
  assign req0_q = p0_req && rst_n_int;
  assign req1_q = p1_req && rst_n_int;

  sp_arbiter #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .CNT_W  (CNT_W)
  ) u_arb (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req0        (req0_q),
    .we0         (p0_we),
    .addr0       (p0_addr),
    .req1        (req1_q),
    .we1         (p1_we),
    .addr1       (p1_addr),
    .gnt0        (gnt0),
    .gnt1        (gnt1),
    .stall_count (stall_count)
  );

  assign p0_gnt = gnt0;
  assign p1_gnt = gnt1;

  logic [BANK_W-1:0] bank0, bank1;
  assign bank0 = p0_addr[BANK_W-1:0];
  assign bank1 = p1_addr[BANK_W-1:0];

  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic              sel0, sel1, en;
    logic              we;
    logic [ROW_W-1:0]  row;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] wdata;

    always_comb begin
      sel0 = gnt0 && (bank0 == BANK_W'(g));
      sel1 = gnt1 && (bank1 == BANK_W'(g));
      en   = sel0 || sel1;
      // Both selected only for a shared read of one word: port 0 fields serve both.
      if (sel0) begin
        we    = p0_we;
        row   = p0_addr[ADDR_W-1:BANK_W];
        be    = p0_be;
        wdata = p0_wdata;
      end else begin
        we    = p1_we;
        row   = p1_addr[ADDR_W-1:BANK_W];
        be    = p1_be;
        wdata = p1_wdata;
      end
    end

    sp_bank #(
      .DEPTH  (BANK_DEPTH),
      .DATA_W (DATA_W)
    ) u_bank (
      .clk   (clk),
      .en    (en),
      .we    (we),
      .row   (row),
      .be    (be),
      .wdata (wdata),
      .rdata (bank_rdata[g])
    );
  end

  // Read return path: one register stage per port.
  logic              rv0_q, rv1_q, rv0_d, rv1_d;
  logic [BANK_W-1:0] rb0_q, rb1_q;

  always_comb begin
    rv0_d = gnt0 && !p0_we;
    rv1_d = gnt1 && !p1_we;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rv0_q <= 1'b0;
      rv1_q <= 1'b0;
      rb0_q <= '0;
      rb1_q <= '0;
    end else begin
      rv0_q <= rv0_d;
      rv1_q <= rv1_d;
      if (rv0_d) rb0_q <= bank0;
      if (rv1_d) rb1_q <= bank1;
    end
  end

  assign p0_rvalid = rv0_q;
  assign p1_rvalid = rv1_q;
  assign p0_rdata  = rv0_q ? bank_rdata[rb0_q] : '0;
  assign p1_rdata  = rv1_q ? bank_rdata[rb1_q] : '0;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              p0_req,
  input logic              p0_we,
  input logic [ADDR_W-1:0] p0_addr,
  input logic              p0_gnt,
  input logic              p0_rvalid,
  input logic              p1_req,
  input logic              p1_we,
  input logic [ADDR_W-1:0] p1_addr,
  input logic              p1_gnt,
  input logic              p1_rvalid,
  input logic [CNT_W-1:0]  stall_count
);
  logic split_banks, shared_read, stalled;
  assign split_banks = p0_addr[BANK_W-1:0] != p1_addr[BANK_W-1:0];
  assign shared_read = !p0_we && !p1_we && (p0_addr == p1_addr);
  assign stalled     = (p0_req && !p0_gnt) || (p1_req && !p1_gnt);

  // R2
  split_bank_both_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_gnt || p1_gnt) && p0_req && p1_req && split_banks |-> p0_gnt && p1_gnt);

  // R1
  clash_one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_gnt || p1_gnt) && p0_req && p1_req && !split_banks && !shared_read
      |-> $countones({p0_gnt, p1_gnt}) == 1);

  // R5
  shared_read_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_gnt || p1_gnt) && p0_req && p1_req && shared_read |-> p0_gnt && p1_gnt);

  // R4
  p0_no_double_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_req && !p0_gnt && p1_gnt) |=> !(p0_req && !p0_gnt));

  // R4
  p1_no_double_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req && !p1_gnt && p0_gnt) |=> !(p1_req && !p1_gnt));

  // R6
  p0_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_gnt && !p0_we) |=> p0_rvalid);

  // R6
  p1_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_gnt && !p1_we) |=> p1_rvalid);

  // R8
  stall_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled && (p0_gnt || p1_gnt) && (stall_count != {CNT_W{1'b1}})
      |=> stall_count == $past(stall_count) + 1'b1);

  // R8
  stall_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stalled |=> $stable(stall_count));

  // R11
  no_spurious_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p0_req |-> !p0_gnt) and (!p1_req |-> !p1_gnt));
endmodule

bind banked_scratchpad sp_checker #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .CNT_W  (CNT_W)
) u_sp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .p0_req      (p0_req),
  .p0_we       (p0_we),
  .p0_addr     (p0_addr),
  .p0_gnt      (p0_gnt),
  .p0_rvalid   (p0_rvalid),
  .p1_req      (p1_req),
  .p1_we       (p1_we),
  .p1_addr     (p1_addr),
  .p1_gnt      (p1_gnt),
  .p1_rvalid   (p1_rvalid),
  .stall_count (stall_count)
);

// File: tb/banked_scratchpad_test.sv
module banked_scratchpad_test;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          p0_req, p0_we, p1_req, p1_we;
  logic [AW-1:0] p0_addr, p1_addr;
  logic [3:0]    p0_be, p1_be;
  logic [DW-1:0] p0_wdata, p1_wdata;
  logic          p0_gnt, p1_gnt, p0_rvalid, p1_rvalid;
  logic [DW-1:0] p0_rdata, p1_rdata;
  logic [15:0]   stall_count;

  always #2.5 clk = ~clk;

  banked_scratchpad uut (
    .clk(clk), .rst_n(rst_n),
    .p0_req(p0_req), .p0_we(p0_we), .p0_addr(p0_addr), .p0_be(p0_be),
    .p0_wdata(p0_wdata), .p0_gnt(p0_gnt), .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
    .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_be(p1_be),
    .p1_wdata(p1_wdata), .p1_gnt(p1_gnt), .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata),
    .stall_count(stall_count)
  );

  // Behavioural reference state
  logic [DW-1:0] ref_mem [4096];
  bit            ref_fav1;
  int            ref_cnt;
  bit            ref_rv0, ref_rv1;
  logic [DW-1:0] ref_rd0, ref_rd1;
  bit            exp_g0, exp_g1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // Inputs are already driven (after a falling edge); compare, then advance the model.
  task automatic step();
    bit clash;
    #1;
    clash  = p0_req && p1_req && (p0_addr % 8 == p1_addr % 8) &&
             !(!p0_we && !p1_we && p0_addr == p1_addr);
    exp_g0 = p0_req && !(clash && ref_fav1);
    exp_g1 = p1_req && !(clash && !ref_fav1);
    chk("R1/R2/R3/R4/R5 p0 grant", p0_gnt, exp_g0);
    chk("R1/R2/R3/R4/R5 p1 grant", p1_gnt, exp_g1);
    chk("R6 p0 rvalid", p0_rvalid, ref_rv0);
    chk("R6 p1 rvalid", p1_rvalid, ref_rv1);
    chk("R6/R7 p0 rdata", p0_rdata, ref_rv0 ? ref_rd0 : 32'h0);
    chk("R6/R7 p1 rdata", p1_rdata, ref_rv1 ? ref_rd1 : 32'h0);
    chk("R8 stall count", stall_count, ref_cnt);
    ref_rv0 = exp_g0 && !p0_we;
    ref_rv1 = exp_g1 && !p1_we;
    if (ref_rv0) ref_rd0 = ref_mem[p0_addr];
    if (ref_rv1) ref_rd1 = ref_mem[p1_addr];
    // R10: only granted writes reach memory
    if (exp_g0 && p0_we) ref_mem[p0_addr] = merge(ref_mem[p0_addr], p0_wdata, p0_be);
    if (exp_g1 && p1_we) ref_mem[p1_addr] = merge(ref_mem[p1_addr], p1_wdata, p1_be);
    if (clash && ref_cnt < 65535) ref_cnt++;
    ref_fav1 = clash && !ref_fav1;
    @(negedge clk);
  endtask

  task automatic idle();
    p0_req = 0; p1_req = 0; p0_we = 0; p1_we = 0;
    p0_addr = '0; p1_addr = '0; p0_be = '0; p1_be = '0;
    p0_wdata = '0; p1_wdata = '0;
  endtask

  task automatic drive(input int port, input bit rq, input bit wr, input int a,
                       input logic [3:0] be, input logic [31:0] d);
    if (port == 0) begin
      p0_req = rq; p0_we = wr; p0_addr = AW'(a); p0_be = be; p0_wdata = d;
    end else begin
      p1_req = rq; p1_we = wr; p1_addr = AW'(a); p1_be = be; p1_wdata = d;
    end
  endtask

  // Holds each port's access until granted (re-presented unchanged).
  task automatic pair(input bit r0, input bit w0, input int a0, input logic [3:0] b0, input logic [31:0] d0,
                      input bit r1, input bit w1, input int a1, input logic [3:0] b1, input logic [31:0] d1);
    bit pend0 = r0, pend1 = r1;
    while (pend0 || pend1) begin
      drive(0, pend0, w0, a0, b0, d0);
      drive(1, pend1, w1, a1, b1, d1);
      step();
      if (exp_g0) pend0 = 0;
      if (exp_g1) pend1 = 0;
    end
    idle();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    ref_fav1 = 0; ref_cnt = 0; ref_rv0 = 0; ref_rv1 = 0; ref_rd0 = '0; ref_rd1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R9: reset state
    #1;
    chk("R9 p0 gnt idle", p0_gnt, 0);
    chk("R9 p1 gnt idle", p1_gnt, 0);
    chk("R9 p0 rvalid", p0_rvalid, 0);
    chk("R9 p1 rvalid", p1_rvalid, 0);
    chk("R9 stall count", stall_count, 0);
    @(negedge clk);

    // Fill: p0 words 0..63, p1 words 64..127 (same bank each pair: R3/R4 clashes)
    for (int i = 0; i < 64; i++)
      pair(1, 1, i, 4'hF, 32'hA000_0000 + i, 1, 1, 64 + i, 4'hF, 32'hB000_0000 + i);

    // R2: neighbouring words in different banks, both read
    for (int i = 0; i < 8; i++) begin
      drive(0, 1, 0, i, 4'h0, 0); drive(1, 1, 0, i + 1, 4'h0, 0); step();
    end
    idle(); step();

    // R1: same low bits, different rows clash; R3 port 0 first
    pair(1, 0, 3, 4'h0, 0, 1, 0, 11, 4'h0, 0);
    // R4: back-to-back clashes alternate
    for (int i = 0; i < 6; i++) begin
      drive(0, 1, 0, 5, 4'h0, 0); drive(1, 1, 0, 13 + 8 * i, 4'h0, 0); step();
    end
    idle(); step();

    // R5: both read one word
    drive(0, 1, 0, 42, 4'h0, 0); drive(1, 1, 0, 42, 4'h0, 0); step();
    idle(); step();

    // R7: partial byte enables
    pair(1, 1, 20, 4'b0101, 32'h1122_3344, 0, 0, 0, 4'h0, 0);
    pair(0, 0, 0, 4'h0, 0, 1, 1, 20, 4'b1000, 32'hEE00_0000);
    pair(1, 0, 20, 4'h0, 0, 0, 0, 0, 4'h0, 0);
    step();

    // R10: stalled write to a word p0 also writes; only granted data lands
    drive(0, 1, 1, 30, 4'hF, 32'h0BAD_F00D); drive(1, 1, 1, 30, 4'hF, 32'hDEAD_BEEF); step();
    drive(0, 1, 0, 30, 4'h0, 0); drive(1, 0, 0, 0, 4'h0, 0); step();
    idle(); step();

    // Mixed traffic over a small window to force clashes
    for (int i = 0; i < 3000; i++) begin
      drive(0, $urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0, $urandom_range(0, 31),
            4'($urandom), $urandom);
      drive(1, $urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0, $urandom_range(0, 31),
            4'($urandom), $urandom);
      step();
    end
    idle(); step();

    // R8: saturate the stall counter with continuous clashes
    drive(0, 1, 0, 2, 4'h0, 0); drive(1, 1, 0, 10, 4'h0, 0);
    while (ref_cnt < 65535) step();
    for (int i = 0; i < 4; i++) step();
    idle(); step();
    chk("R8 saturated", stall_count, 16'hFFFF);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule